// File: doc/BRIEF.md
# CRC32C Accumulate Execution Unit

This unit executes a processor-style CRC accumulate operation over the Castagnoli generator (0x1_1EDC6F41). A caller supplies a 32-bit running checksum, a data operand of 8, 16, 32 or 64 bits and a size code. The unit returns the updated 32-bit checksum. It applies no inversion before or after the update, so software performs the usual seed and final complement around a chain of operations.

Internally, the running checksum and the operand are bit-reversed. The two are merged into a 64-bit dividend, which is reduced by an MSB-first modulo-2 long division at one dividend bit per clock. The remainder is reversed back. A 64-bit operand runs as two chained 32-bit passes, with the low half first.

The unit accepts work through a start pulse and reports through busy and a one-cycle done strobe. A build can leave out 64-bit support. In that case the 64-bit size code raises an error strobe and no work is started.

Top module: `crc32c_seq_unit`

## Requirements
- R1: After reset, busy, done and error are 0 and crc_out is 0.
- R2: Size code 0 updates the checksum with the byte data_in[7:0]. The result equals the LSB-first (reflected) CRC32C update using constant 0x82F63B78, with no inversion.
- R3: Size code 1 equals two byte updates: data_in[7:0] first, then data_in[15:8].
- R4: Size code 2 equals four byte updates in ascending byte order over data_in[31:0].
- R5: Size code 3 equals a size-2 update over data_in[31:0], followed by a size-2 update over data_in[63:32] that starts from that result.
- R6: A start seen while idle raises busy on the accepting edge. For size codes 0 to 2, done is high for exactly one cycle, 33 edges after the accepting edge; for size code 3 this is 66 edges. Busy falls on the edge on which done rises.
- R7: A start while busy is ignored. The result and the timing of the running operation are unchanged.
- R8: crc_out holds its value between operations, and data bits above the selected width have no effect on the result.
- R9: In a build with 64-bit support disabled, size code 3 with start raises error for one cycle on the next edge. Busy stays 0 and crc_out is unchanged.
- R10: Chaining the bytes of "123456789" through size-0 operations, from 0xFFFFFFFF, and complementing the final value gives 0xE3069283.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a new operation (sampled when idle) |
| size | input | 2 | Operand width code: 0=8, 1=16, 2=32, 3=64 bits |
| acc_in | input | 32 | Running checksum |
| data_in | input | 64 | Data operand, low bits used for smaller sizes |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion strobe |
| crc_out | output | 32 | Updated checksum, held until the next completion |
| error | output | 1 | One-cycle strobe for an unsupported size code |

## Verification
Each size is run with all-zero, all-one and alternating operands against several running values. These runs separate an error in the reflection or byte order from an error in the polynomial step. Junk above the selected width shows whether the width masking is correct. The standard check string, run as byte steps, pins down the generator constant. Comparing one 32-bit or 64-bit operation against the equivalent byte chain shows whether the two-pass chaining and the half order are right. A start injected mid-operation, and a separate build without 64-bit support, cover the ignore and error paths.

// File: rtl/crc32c_pkg.sv
package crc32c_pkg;
    localparam int CRC_W = 32;
    localparam logic [CRC_W:0] GEN_POLY = 33'h1_1EDC6F41;

    typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_RUN} phase_t;

    typedef struct packed {
        phase_t            phase;
        logic              second;
        logic [4:0]        step;
        logic [CRC_W-1:0]  rem;
        logic [CRC_W-1:0]  tail;
        logic [CRC_W-1:0]  acc;
        logic [63:0]       data;
        logic [1:0]        size;
        logic [CRC_W-1:0]  crc;
        logic              done;
        logic              err;
    } unit_state_t;

    function automatic logic [CRC_W-1:0] rev_word(input logic [CRC_W-1:0] v);
        logic [CRC_W-1:0] r;
        for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
        return r;
    endfunction
endpackage

// File: rtl/crc32c_dividend_form.sv
module crc32c_dividend_form
    import crc32c_pkg::*;
(
    input  logic [CRC_W-1:0]   acc,
    input  logic [CRC_W-1:0]   word,
    input  logic [1:0]         size,
    output logic [2*CRC_W-1:0] dividend
);
    logic [CRC_W-1:0] masked;
    logic [CRC_W-1:0] dref;
    logic [2*CRC_W-1:0] acc_part;

    always_comb begin
        case (size)
            2'd0:    masked = {24'b0, word[7:0]};
            2'd1:    masked = {16'b0, word[15:0]};
            default: masked = word;
        endcase
        case (size)
            2'd0:    dref = rev_word(masked) >> 24;
            2'd1:    dref = rev_word(masked) >> 16;
            default: dref = rev_word(masked);
        endcase
        case (size)
            2'd0:    acc_part = {32'b0, rev_word(acc)} << 8;
            2'd1:    acc_part = {32'b0, rev_word(acc)} << 16;
            default: acc_part = {32'b0, rev_word(acc)} << 32;
        endcase
        dividend = {dref, 32'b0} ^ acc_part;
    end
endmodule

// File: rtl/crc32c_div_step.sv
module crc32c_div_step
    import crc32c_pkg::*;
(
    input  logic [CRC_W-1:0] rem,
    input  logic             bit_in,
    output logic [CRC_W-1:0] rem_nxt
);
    logic [CRC_W:0] widened;

    always_comb begin
        widened = {rem, bit_in};
        if (widened[CRC_W]) widened = widened ^ GEN_POLY;
        rem_nxt = widened[CRC_W-1:0];
    end
endmodule

// File: rtl/crc32c_seq_unit.sv
module crc32c_seq_unit
    import crc32c_pkg::*;
#(
    parameter bit ALLOW_QWORD = 1'b1
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start,
    input  logic [1:0]  size,
    input  logic [31:0] acc_in,
    input  logic [63:0] data_in,
    output logic        busy,
    output logic        done,
    output logic [31:0] crc_out,
    output logic        error
);
    localparam logic [4:0] LAST_STEP = 5'(CRC_W - 1);

    unit_state_t st_q, st_d;
    logic [2*CRC_W-1:0] dividend;
    logic [CRC_W-1:0]   step_out;
    logic [CRC_W-1:0]   cur_word;

    assign cur_word = st_q.second ? st_q.data[63:32] : st_q.data[31:0];

    crc32c_dividend_form u_form (
        .acc      (st_q.acc),
        .word     (cur_word),
        .size     (st_q.size),
        .dividend (dividend)
    );

    crc32c_div_step u_step (
        .rem     (st_q.rem),
        .bit_in  (st_q.tail[CRC_W-1]),
        .rem_nxt (step_out)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        st_d.err  = 1'b0;
        case (st_q.phase)
            ST_IDLE: begin
                if (start) begin
                    if (size == 2'd3 && !ALLOW_QWORD) begin
                        st_d.err = 1'b1;
                    end else begin
                        st_d.phase  = ST_SETUP;
                        st_d.second = 1'b0;
                        st_d.acc    = acc_in;
                        st_d.data   = data_in;
                        st_d.size   = size;
                    end
                end
            end
            ST_SETUP: begin
                st_d.rem   = dividend[2*CRC_W-1:CRC_W];
                st_d.tail  = dividend[CRC_W-1:0];
                st_d.step  = '0;
                st_d.phase = ST_RUN;
            end
            default: begin
                st_d.rem  = step_out;
                st_d.tail = st_q.tail << 1;
                st_d.step = st_q.step + 5'd1;
                if (st_q.step == LAST_STEP) begin
                    if (st_q.size == 2'd3 && !st_q.second) begin
                        st_d.acc    = rev_word(step_out);
                        st_d.second = 1'b1;
                        st_d.phase  = ST_SETUP;
                    end else begin
                        st_d.crc   = rev_word(step_out);
                        st_d.done  = 1'b1;
                        st_d.phase = ST_IDLE;
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign busy    = (st_q.phase != ST_IDLE);
    assign done    = st_q.done;
    assign crc_out = st_q.crc;
    assign error   = st_q.err;

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R6
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $fell(busy));
    // R7
    start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(st_q.size) && $stable(st_q.data)));
    // R8
    crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(crc_out));
    // R9
    err_no_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> (!busy && !done));
endmodule

// File: tb/crc32c_seq_unit_tb.sv
module crc32c_seq_unit_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [1:0] size = '0;
    logic [31:0] acc_in = '0;
    logic [63:0] data_in = '0;
    logic busy, done, error;
    logic [31:0] crc_out;

    logic start2 = 1'b0;
    logic busy2, done2, error2;
    logic [31:0] crc_out2;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    crc32c_seq_unit u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .size(size),
        .acc_in(acc_in), .data_in(data_in), .busy(busy), .done(done),
        .crc_out(crc_out), .error(error)
    );

    crc32c_seq_unit #(.ALLOW_QWORD(1'b0)) u_dut_noq (
        .clk(clk), .rst_n(rst_n), .start(start2), .size(size),
        .acc_in(acc_in), .data_in(data_in), .busy(busy2), .done(done2),
        .crc_out(crc_out2), .error(error2)
    );

    function automatic logic [31:0] ref_crc(input logic [31:0] acc,
                                            input logic [63:0] d, input int nbytes);
        logic [31:0] c = acc;
        for (int i = 0; i < nbytes; i++) begin
            c ^= {24'b0, d[8*i +: 8]};
            for (int j = 0; j < 8; j++)
                c = c[0] ? ((c >> 1) ^ 32'h82F63B78) : (c >> 1);
        end
        return c;
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic run_op(input logic [1:0] sz, input logic [31:0] acc,
                          input logic [63:0] d, input bit poke, input string tag,
                          output logic [31:0] res);
        int nb = (sz == 2'd3) ? 8 : (1 << sz);
        int lat = (sz == 2'd3) ? 67 : 34;
        logic [31:0] exp = ref_crc(acc, d, nb);
        @(negedge clk);
        size = sz; acc_in = acc; data_in = d; start = 1'b1;
        for (int k = 1; k <= lat; k++) begin
            @(negedge clk);
            start = 1'b0;
            chk(busy == (k < lat), {tag, " R6 busy"}, 64'(busy), 64'(k < lat));
            chk(done == (k == lat), {tag, " R6 done"}, 64'(done), 64'(k == lat));
            if (poke && k == 5) begin
                // R7: start while busy with other operands
                start = 1'b1; size = 2'd0; acc_in = ~acc; data_in = ~d;
            end
        end
        chk(crc_out == exp, tag, 64'(crc_out), 64'(exp));
        res = crc_out;
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            // R8: held after completion
            chk(crc_out == exp && !done, {tag, " R8 hold"}, 64'(crc_out), 64'(exp));
        end
    endtask

    initial begin : wd
        repeat (20000) @(posedge clk);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        logic [31:0] r, c;
        logic [63:0] s;
        s = "12345678";
        repeat (3) @(negedge clk);
        // R1
        chk(!busy && !done && !error && crc_out == 0, "R1 reset", 64'(crc_out), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !done && !error && crc_out == 0, "R1 after release", 64'(busy), 0);

        run_op(2'd0, 32'h0, 64'h00, 0, "R2 zero", r);
        run_op(2'd0, 32'hFFFFFFFF, 64'hFF, 0, "R2 ones", r);
        run_op(2'd0, 32'h12345678, 64'hA5, 0, "R2 mixed", r);
        run_op(2'd1, 32'hDEADBEEF, 64'h5AC3, 0, "R3 half", r);
        run_op(2'd1, 32'h0, 64'hFFFF, 0, "R3 ones", r);
        run_op(2'd2, 32'hCAFEF00D, 64'h01234567, 0, "R4 word", r);
        run_op(2'd2, 32'hFFFFFFFF, 64'hAAAAAAAA, 0, "R4 alt", r);
        run_op(2'd3, 32'h89ABCDEF, 64'h0011223344556677, 0, "R5 dword", r);
        run_op(2'd3, 32'h0, 64'hFFFFFFFF00000000, 0, "R5 highonly", r);
        // R8: junk above the width
        run_op(2'd0, 32'h76543210, 64'hFFFFFFFFFFFFFF3C, 0, "R8 junk8", r);
        run_op(2'd1, 32'h76543210, 64'h123456789ABC3C3C, 0, "R8 junk16", r);
        // R7: start while busy
        run_op(2'd2, 32'h0BADF00D, 64'h55AA33CC, 1, "R7 poke", r);
        run_op(2'd3, 32'h0BADF00D, 64'h55AA33CC11223344, 1, "R7 poke64", r);

        // R10: check string through byte steps
        c = 32'hFFFFFFFF;
        for (int i = 0; i < 9; i++) begin
            run_op(2'd0, c, 64'(8'h31 + i), 0, "R10 step", r);
            c = r;
        end
        chk(~c == 32'hE3069283, "R10 check value", 64'(~c), 64'hE3069283);

        // R5: 64-bit op equals byte chain
        c = 32'h1F2E3D4C;
        for (int i = 0; i < 8; i++) begin
            run_op(2'd0, c, 64'(s[8*i +: 8]), 0, "R5 chain", r);
            c = r;
        end
        run_op(2'd3, 32'h1F2E3D4C, s, 0, "R5 single", r);
        chk(r == c, "R5 single vs chain", 64'(r), 64'(c));
        // R4: 32-bit op equals byte chain
        c = 32'h1F2E3D4C;
        for (int i = 0; i < 4; i++) begin
            run_op(2'd0, c, 64'(s[8*i +: 8]), 0, "R4 chain", r);
            c = r;
        end
        run_op(2'd2, 32'h1F2E3D4C, s, 0, "R4 single", r);
        chk(r == c, "R4 single vs chain", 64'(r), 64'(c));

        // R9: unsupported size in the reduced build
        @(negedge clk);
        size = 2'd3; acc_in = 32'h11111111; data_in = 64'h1; start2 = 1'b1;
        @(negedge clk);
        start2 = 1'b0;
        chk(error2 && !busy2, "R9 error raised", {error2, busy2}, 2'b10);
        @(negedge clk);
        chk(!error2 && !busy2 && !done2, "R9 error single", 64'(error2), 0);
        chk(crc_out2 == 0, "R9 crc unchanged", 64'(crc_out2), 0);

        finished = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule